// File: doc/BRIEF.md
# Counter Read Permission and Overflow Summary

This block sits beside a core's CSR file. It decides whether a read of one of the user-visible performance counter registers may proceed. It also produces the read-only word that collects per-counter overflow flags. For each CSR address it looks at the current privilege level, the virtualization state, the machine-level and hypervisor-level counter-enable masks, the mask of implemented counters and the overflow-feature enable. From these it returns one of three verdicts: allow, illegal instruction, or virtual-instruction fault.

The summary word gathers the per-counter overflow flags. Only counters that the machine counter-enable mask exposes appear in it. The three fixed counters (cycle, time, instret) always read as zero there.

Both results are computed combinationally. They are captured in one register stage, so the verdict for the address presented before a rising edge is visible after that edge. The surrounding CSR logic turns a non-allow verdict into the matching trap.

Top module: `ctr_gate`

## Requirements
- R1: The counter index is the CSR address minus 0xC00 for the low block (0xC00 to 0xC1F). In 32-bit mode (`xlen32_i`=1) it is the address minus 0xC80 for the upper-half block (0xC80 to 0xC9F). With `xlen32_i`=0 the upper-half block is not claimed. Any address the block does not claim returns verdict 0 (allow).
- R2: Indices 0, 1 and 2 (cycle, time, instret) skip the implemented-counter check. Their verdict does not depend on `avail_i`.
- R3: A claimed counter with index 3 or higher whose `avail_i` bit is clear gives verdict 1 (illegal instruction). This holds at every privilege level.
- R4: At privilege 2'b11 (M), every implemented or fixed counter gives verdict 0, whatever the enable masks hold.
- R5: At privilege 2'b01 (S) or 2'b00 (U), a counter whose `mcen_i` bit is clear gives verdict 1.
- R6: With `virt_i`=1 at S or U, a counter whose `mcen_i` bit is set and whose `hcen_i` bit is clear gives verdict 2 (virtual-instruction fault). When both bits are set the verdict is 0.
- R7: Summary bit i, for i from 3 up, equals `mcen_i[i] & ovf_i[i]`. Bits 0 to 2 are always 0.
- R8: With `ofl_feat_i`=0, address 0xDA0 (summary word) and addresses 0x723 to 0x73F (upper halves of the event selectors) give verdict 1. With `ofl_feat_i`=1 they give verdict 0.
- R9: Both outputs are registered. They show the result for the inputs sampled at the previous rising edge. Reset forces the verdict to 0 and the summary to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address being read |
| priv_i | input | 2 | Privilege level: 0 U, 1 S, 3 M |
| virt_i | input | 1 | Virtualized execution |
| xlen32_i | input | 1 | 32-bit register mode, enables the upper-half block |
| ofl_feat_i | input | 1 | Overflow feature enabled |
| mcen_i | input | 32 | Machine counter-enable mask |
| hcen_i | input | 32 | Hypervisor counter-enable mask |
| avail_i | input | 32 | Implemented-counter mask |
| ovf_i | input | 32 | Per-counter overflow flags |
| verdict_o | output | 2 | 0 allow, 1 illegal, 2 virtual fault |
| ovf_sum_o | output | 32 | Overflow summary word |

## Verification
The bench builds the block with its default parameters. That means 32 counters, the first programmable counter at index 3, and the standard bases of 0xC00, 0xC80, 0x723 and 0xDA0. These values bring both ends of each address window into reach: index 31 at 0xC1F and 0x73F, and the fixed indices 0 to 2. They also reach the boundary between fixed and programmable counters at index 3. A single 32-bit width means the summary masking and the three forced-zero low bits are checked against full-word patterns.

// File: rtl/ctr_gate_pkg.sv
package ctr_gate_pkg;
  typedef enum logic [1:0] {
    VERD_OK      = 2'd0,
    VERD_ILLEGAL = 2'd1,
    VERD_VIRT    = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_CTR  = 2'd1,
    K_SUM  = 2'd2,
    K_SELH = 2'd3
  } kind_e;
endpackage

// File: rtl/ctr_addr_dec.sv
module ctr_addr_dec
  import ctr_gate_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NCTR        = 32,
  parameter int FIRST_PROG  = 3,
  parameter int CTR_LO_BASE = 'hC00,
  parameter int CTR_HI_BASE = 'hC80,
  parameter int SELH_BASE   = 'h720,
  parameter int SUM_ADDR    = 'hDA0,
  localparam int IDX_W      = $clog2(NCTR)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              xlen32_i,
  output kind_e             kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] NCTR_A = ADDR_W'(NCTR);
  localparam logic [ADDR_W-1:0] FP_A   = ADDR_W'(FIRST_PROG);
  localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(CTR_LO_BASE);
  localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(CTR_HI_BASE);
  localparam logic [ADDR_W-1:0] SELH_A = ADDR_W'(SELH_BASE);
  localparam logic [ADDR_W-1:0] SUM_A  = ADDR_W'(SUM_ADDR);

  logic [ADDR_W-1:0] off_lo, off_hi, off_sel;
  logic              hit_lo, hit_hi, hit_sel;

  assign off_lo  = addr_i - LO_A;
  assign off_hi  = addr_i - HI_A;
  assign off_sel = addr_i - SELH_A;
  assign hit_lo  = off_lo < NCTR_A;
  assign hit_hi  = xlen32_i && (off_hi < NCTR_A);
  assign hit_sel = (off_sel < NCTR_A) && (off_sel >= FP_A);

  always_comb begin
    kind_o = K_NONE;
    idx_o  = '0;
    if (addr_i == SUM_A) begin
      kind_o = K_SUM;
    end else if (hit_sel) begin
      kind_o = K_SELH;
      idx_o  = off_sel[IDX_W-1:0];
    end else if (hit_lo) begin
      kind_o = K_CTR;
      idx_o  = off_lo[IDX_W-1:0];
    end else if (hit_hi) begin
      kind_o = K_CTR;
      idx_o  = off_hi[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/ctr_perm.sv
module ctr_perm
  import ctr_gate_pkg::*;
#(
  parameter int NCTR       = 32,
  parameter int FIRST_PROG = 3,
  localparam int IDX_W     = $clog2(NCTR)
) (
  input  kind_e            kind_i,
  input  logic [IDX_W-1:0] idx_i,
  input  priv_e            priv_i,
  input  logic             virt_i,
  input  logic             feat_i,
  input  logic [NCTR-1:0]  mcen_i,
  input  logic [NCTR-1:0]  hcen_i,
  input  logic [NCTR-1:0]  avail_i,
  output verdict_e         verdict_o
);
  localparam logic [IDX_W-1:0] FP_I = IDX_W'(FIRST_PROG);

  logic fixed_ctr;
  assign fixed_ctr = idx_i < FP_I;

  always_comb begin
    verdict_o = VERD_OK;
    unique case (kind_i)
      K_SUM, K_SELH: verdict_o = feat_i ? VERD_OK : VERD_ILLEGAL;
      K_CTR: begin
        if (!fixed_ctr && !avail_i[idx_i])  verdict_o = VERD_ILLEGAL;
        else if (priv_i == PRIV_M)          verdict_o = VERD_OK;
        else if (!mcen_i[idx_i])            verdict_o = VERD_ILLEGAL;
        else if (virt_i && !hcen_i[idx_i])  verdict_o = VERD_VIRT;
        else                                verdict_o = VERD_OK;
      end
      default: verdict_o = VERD_OK;
    endcase
  end
endmodule

// File: rtl/ovf_summary.sv
module ovf_summary #(
  parameter int NCTR       = 32,
  parameter int FIRST_PROG = 3
) (
  input  logic [NCTR-1:0] mcen_i,
  input  logic [NCTR-1:0] ovf_i,
  output logic [NCTR-1:0] sum_o
);
  for (genvar i = 0; i < NCTR; i++) begin : g_bit
    if (i < FIRST_PROG) begin : g_fixed
      assign sum_o[i] = 1'b0;
    end else begin : g_prog
      assign sum_o[i] = mcen_i[i] & ovf_i[i];
    end
  end
endmodule

// File: rtl/ctr_gate.sv
module ctr_gate
  import ctr_gate_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NCTR       = 32,
  parameter int FIRST_PROG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic              xlen32_i,
  input  logic              ofl_feat_i,
  input  logic [NCTR-1:0]   mcen_i,
  input  logic [NCTR-1:0]   hcen_i,
  input  logic [NCTR-1:0]   avail_i,
  input  logic [NCTR-1:0]   ovf_i,
  output logic [1:0]        verdict_o,
  output logic [NCTR-1:0]   ovf_sum_o
);
  localparam int IDX_W = $clog2(NCTR);
  localparam logic [IDX_W-1:0] FP_I = IDX_W'(FIRST_PROG);

  kind_e            kind_w;
  logic [IDX_W-1:0] idx_w;
  verdict_e         verdict_w;
  logic [NCTR-1:0]  sum_w;
  priv_e            priv_w;

  assign priv_w = priv_e'(priv_i);

  ctr_addr_dec #(
    .ADDR_W(ADDR_W), .NCTR(NCTR), .FIRST_PROG(FIRST_PROG)
  ) i_dec (
    .addr_i  (csr_addr_i),
    .xlen32_i(xlen32_i),
    .kind_o  (kind_w),
    .idx_o   (idx_w)
  );

  ctr_perm #(.NCTR(NCTR), .FIRST_PROG(FIRST_PROG)) i_perm (
    .kind_i   (kind_w),
    .idx_i    (idx_w),
    .priv_i   (priv_w),
    .virt_i   (virt_i),
    .feat_i   (ofl_feat_i),
    .mcen_i   (mcen_i),
    .hcen_i   (hcen_i),
    .avail_i  (avail_i),
    .verdict_o(verdict_w)
  );

  ovf_summary #(.NCTR(NCTR), .FIRST_PROG(FIRST_PROG)) i_sum (
    .mcen_i(mcen_i),
    .ovf_i (ovf_i),
    .sum_o (sum_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      verdict_o <= VERD_OK;
      ovf_sum_o <= '0;
    end else begin
      verdict_o <= verdict_w;
      ovf_sum_o <= sum_w;
    end
  end

  // R4
  m_mode_allow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_w == K_CTR && priv_i == 2'b11 && (idx_w < FP_I || avail_i[idx_w]))
    |=> verdict_o == 2'd0);

  // R8
  feat_off_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ofl_feat_i && (kind_w == K_SUM || kind_w == K_SELH)) |=> verdict_o == 2'd1);

  // R6
  virt_fault_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (verdict_o != 2'd2 || ($past(virt_i) && $past(priv_i) != 2'b11)));

  // R7
  sum_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_sum_o[FIRST_PROG-1:0] == '0);

  // R7
  sum_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ovf_sum_o & ~$past(mcen_i)) == '0);

  // R3
  unavail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_w == K_CTR && idx_w >= FP_I && !avail_i[idx_w]) |=> verdict_o == 2'd1);
endmodule

// File: tb/test_ctr_gate.sv
module test_ctr_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  priv = '0;
  logic        virt = 1'b0, x32 = 1'b0, fen = 1'b0;
  logic [31:0] mcen = '0, hcen = '0, avail = '0, ovf = '0;
  logic [1:0]  verdict;
  logic [31:0] sum;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  typedef struct {
    logic [1:0]  v;
    logic [31:0] s;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  ctr_gate i_ctr_gate (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .priv_i(priv),
    .virt_i(virt), .xlen32_i(x32), .ofl_feat_i(fen), .mcen_i(mcen),
    .hcen_i(hcen), .avail_i(avail), .ovf_i(ovf),
    .verdict_o(verdict), .ovf_sum_o(sum)
  );

  function automatic logic [1:0] model_v(logic [11:0] a, logic [1:0] p, logic vt,
      logic x, logic f, logic [31:0] mc, logic [31:0] hc, logic [31:0] av);
    logic lo, hi;
    int   idx;
    if (a == 12'hDA0 || (a >= 12'h723 && a <= 12'h73F)) return f ? 2'd0 : 2'd1;
    lo = (a >= 12'hC00 && a <= 12'hC1F);
    hi = x && (a >= 12'hC80 && a <= 12'hC9F);
    if (!lo && !hi) return 2'd0;
    idx = int'(a[4:0]);
    if (idx >= 3 && !av[idx]) return 2'd1;
    if (p == 2'b11) return 2'd0;
    if (!mc[idx]) return 2'd1;
    if (vt && !hc[idx]) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [31:0] model_s(logic [31:0] mc, logic [31:0] ov);
    return mc & ov & 32'hFFFF_FFF8;
  endfunction

  task automatic drive(input logic [11:0] a, input logic [1:0] p, input logic vt,
      input logic x, input logic f, input logic [31:0] mc, input logic [31:0] hc,
      input logic [31:0] av, input logic [31:0] ov, input string tag);
    exp_t it;
    @(negedge clk);
    addr = a; priv = p; virt = vt; x32 = x; fen = f;
    mcen = mc; hcen = hc; avail = av; ovf = ov;
    it.v = model_v(a, p, vt, x, f, mc, hc, av);
    it.s = model_s(mc, ov);
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (verdict !== it.v || sum !== it.s) begin
          errors++;
          $display("FAIL %s verdict=%0d sum=%h expected verdict=%0d sum=%h",
                   it.tag, verdict, sum, it.v, it.s);
        end
      end
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  endtask

  initial begin : watchdog
    #40000;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R9 reset state
    if (verdict !== 2'd0 || sum !== 32'h0) begin
      errors++;
      $display("FAIL R9 reset verdict=%0d sum=%h expected 0 0", verdict, sum);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 fixed counters, nothing implemented
    for (int i = 0; i < 3; i++)
      drive(12'hC00 + 12'(i), 2'b01, 0, 0, 1, '1, '1, '0, '0, "R2");
    // R3 programmable counter missing from avail, even in M mode
    drive(12'hC07, 2'b01, 0, 0, 1, '1, '1, 32'h0000_0020, '0, "R3");
    drive(12'hC07, 2'b11, 0, 0, 1, '1, '1, 32'h0000_0020, '0, "R3_m");
    drive(12'hC03, 2'b01, 0, 0, 1, '1, '1, 32'h0000_0008, '0, "R3_first");
    // R1 upper block and xlen
    drive(12'hC85, 2'b01, 0, 1, 1, 32'h20, '0, 32'h20, '0, "R1_hi_ok");
    drive(12'hC86, 2'b01, 0, 1, 1, '1, '1, 32'h20, '0, "R1_hi_unavail");
    drive(12'hC86, 2'b01, 0, 0, 1, '1, '1, 32'h20, '0, "R1_hi_unclaimed");
    drive(12'hC1F, 2'b01, 0, 0, 1, 32'h8000_0000, '0, 32'h8000_0000, '0, "R1_top");
    drive(12'hC20, 2'b00, 0, 0, 1, '0, '0, '0, '0, "R1_outside");
    // R4 M mode ignores enables
    drive(12'hC05, 2'b11, 1, 0, 1, '0, '0, 32'h20, '0, "R4");
    drive(12'hC01, 2'b11, 0, 0, 1, '0, '0, '0, '0, "R4_fixed");
    // R5 S/U enable gating
    drive(12'hC04, 2'b01, 0, 0, 1, 32'hFFFF_FFEF, '1, '1, '0, "R5_s");
    drive(12'hC04, 2'b00, 0, 0, 1, 32'hFFFF_FFEF, '1, '1, '0, "R5_u");
    drive(12'hC00, 2'b01, 0, 0, 1, 32'hFFFF_FFFE, '1, '1, '0, "R5_cycle");
    drive(12'hC04, 2'b01, 0, 0, 1, 32'h10, '0, '1, '0, "R5_ok");
    // R6 virtualized
    drive(12'hC09, 2'b01, 1, 0, 1, '1, 32'hFFFF_FDFF, '1, '0, "R6_vs");
    drive(12'hC09, 2'b00, 1, 0, 1, '1, 32'hFFFF_FDFF, '1, '0, "R6_vu");
    drive(12'hC09, 2'b01, 1, 0, 1, 32'hFFFF_FDFF, '0, '1, '0, "R6_mclear");
    drive(12'hC09, 2'b01, 1, 0, 1, '1, '1, '1, '0, "R6_ok");
    drive(12'hC02, 2'b00, 1, 0, 1, '1, '0, '0, '0, "R6_fixed");
    // R8 feature gating
    drive(12'hDA0, 2'b01, 0, 0, 0, '1, '1, '1, '1, "R8_sum_off");
    drive(12'h723, 2'b11, 0, 1, 0, '1, '1, '1, '0, "R8_selh_lo");
    drive(12'h73F, 2'b11, 0, 1, 0, '1, '1, '1, '0, "R8_selh_hi");
    drive(12'h722, 2'b11, 0, 1, 0, '1, '1, '1, '0, "R8_selh_below");
    drive(12'hDA0, 2'b01, 0, 0, 1, '1, '1, '1, '1, "R8_sum_on");
    // R7 summary patterns
    drive(12'hDA0, 2'b01, 0, 0, 1, 32'h0000_F0F0, '0, '0, 32'hFF00_FF0F, "R7_mix");
    drive(12'hDA0, 2'b01, 0, 0, 1, 32'h0000_0007, '0, '0, 32'h0000_0007, "R7_low");
    drive(12'hDA0, 2'b01, 0, 0, 1, '0, '0, '0, '1, "R7_none");
    drive(12'hDA0, 2'b01, 0, 0, 1, 32'hAAAA_5555, '0, '0, 32'h6666_FFFF, "R7_alt");

    repeat (3) @(posedge clk);
    #2;
    report();
  end
endmodule